// File: doc/BRIEF.md
# Power-Gate Clamp Release Sequencer

This block brings pad power domains out of low-power isolation in a safe, timed order. It owns a 32-bit isolation control word. The word holds one shared auxiliary group in its top three bits and a row of per-port groups packed three bits per port from bit 0 upward. After reset every bit is one, so every domain starts clamped and powered down.

A single-cycle `start` pulse chooses a target. The target is either the shared group (`sel_shared` high) or one port (`port_idx`). For that target the sequencer clears three active-high controls in a fixed order: first the clamp, then the early clamp, then core-voltage-down. A programmable wait separates each step. The wait is counted in pulses of the microsecond `tick` input; the nominal value is 200.

`done` pulses when a request has finished. A sticky flag remembers that the shared group has been released, and any later shared request then completes at once. A port index that does not exist raises `err` and leaves the word untouched.

Top module: `gate_clamp_release_seq`

## Requirements
- R1: After reset `pad_ctrl` is all ones, and `busy`, `done`, `err` and `shared_on` are low.
- R2: Port n owns three bits of `pad_ctrl`: clamp at bit 3n, early clamp at bit 3n+1 and core-voltage-down at bit 3n+2. A port request changes no other bit. Bits only ever go from one to zero, and at most one bit changes per cycle.
- R3: When `sel_shared` is high the target is the shared group, and `port_idx` is ignored. The shared group uses bit 29 for clamp, bit 30 for early clamp and bit 31 for core-voltage-down.
- R4: The clamp bit clears at the clock edge that accepts `start`. The early clamp bit clears at the edge that samples the WAIT_TICKS-th `tick` after that edge. Core-voltage-down clears at the edge that samples the WAIT_TICKS-th `tick` after the early clamp bit cleared.
- R5: Only cycles with `tick` high advance a wait. Any number of cycles without a tick leaves the sequence parked at its current step.
- R6: `done` is high for exactly one cycle, the cycle after core-voltage-down clears. `busy` is high from the cycle after acceptance until that same cycle, in which it is already low.
- R7: Once a shared-group sequence completes, `shared_on` stays high. A later shared request then raises `done` the next cycle, leaves `pad_ctrl` unchanged and never raises `busy`.
- R8: A `start` that arrives while `busy` is high is ignored: the running sequence continues unchanged and the other target's bits stay set.
- R9: A port request with `port_idx` >= NUM_PORTS raises `err` and `done` together for one cycle, leaves `pad_ctrl` unchanged and never raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per microsecond time unit |
| start | input | 1 | Request pulse, sampled when idle |
| sel_shared | input | 1 | Target the shared group instead of a port |
| port_idx | input | IDX_W (4) | Port index of a port request |
| busy | output | 1 | A release sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a nonexistent port index |
| shared_on | output | 1 | Sticky flag: shared group has been released |
| pad_ctrl | output | 32 | Isolation control word |

## Verification
Port requests go to the lowest port, the highest port and a middle port. This separates the bit-position arithmetic from off-by-one packing errors. A request issued mid-sequence shows whether a start pulse is ignored or wrongly retargets the sequence. Stopping `tick` for many cycles separates tick counting from cycle counting. Two shared requests in a row, followed by indices just past and far past the last port, separate the sticky completion path from the error path, and both from a sequence that would wrongly run.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    localparam int CTRL_W      = 32;
    localparam int POS_W       = 5;
    localparam int SHARED_BASE = 29;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_EARLY = 2'd1,
        ST_WAIT_VCORE = 2'd2
    } seq_state_e;

    // offset of each control inside a three-bit group
    localparam logic [POS_W-1:0] STEP_CLAMP = 5'd0;
    localparam logic [POS_W-1:0] STEP_EARLY = 5'd1;
    localparam logic [POS_W-1:0] STEP_VCORE = 5'd2;

endpackage

// File: rtl/gate_target_decode.sv
module gate_target_decode
    import gate_seq_pkg::*;
#(
    parameter int NUM_PORTS = 7,
    parameter int IDX_W     = 4
) (
    input  logic             sel_shared,
    input  logic [IDX_W-1:0] port_idx,
    output logic             in_range,
    output logic [POS_W-1:0] base_pos
);
    localparam int LAST_BIT = 3 * NUM_PORTS - 1;

    // the port groups must stay clear of the shared group
    if (LAST_BIT >= SHARED_BASE) begin : g_bad_cfg
        initial $error("NUM_PORTS too large for the control word");
    end

    logic [31:0] scaled;

    always_comb begin
        scaled   = 32'(port_idx) * 32'd3;
        in_range = sel_shared || (32'(port_idx) < 32'(NUM_PORTS));
        if (sel_shared) begin
            base_pos = POS_W'(SHARED_BASE);
        end else begin
            base_pos = scaled[POS_W-1:0];
        end
    end

endmodule

// File: rtl/gate_tick_timer.sv
module gate_tick_timer #(
    parameter int WAIT_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = (WAIT_TICKS < 2) ? 1 : $clog2(WAIT_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && tick && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (!run || expire) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/gate_ctrl_word.sv
module gate_ctrl_word
    import gate_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [POS_W-1:0]  clr_pos,
    output logic [CTRL_W-1:0] word
);
    logic [CTRL_W-1:0] word_d, word_q;

    for (genvar g = 0; g < CTRL_W; g++) begin : g_bit
        always_comb begin
            word_d[g] = word_q[g] & ~(clr_en && (clr_pos == POS_W'(g)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '1;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;

    a_r2_never_set: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q & ~$past(word_q)) == '0);
    a_r2_one_bit_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(word_q ^ $past(word_q)) <= 1);

endmodule

// File: rtl/gate_clamp_fsm.sv
module gate_clamp_fsm
    import gate_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sel_shared,
    input  logic             in_range,
    input  logic [POS_W-1:0] base_pos,
    input  logic             expire,
    output logic             clr_en,
    output logic [POS_W-1:0] clr_pos,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             shared_on
);
    typedef struct packed {
        seq_state_e       state;
        logic [POS_W-1:0] base;
        logic             tgt_shared;
        logic             shared_on;
        logic             done;
        logic             err;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        clr_en   = 1'b0;
        clr_pos  = s_q.base;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (sel_shared && s_q.shared_on) begin
                        s_d.done = 1'b1;
                    end else if (!in_range) begin
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                    end else begin
                        clr_en         = 1'b1;
                        clr_pos        = base_pos + STEP_CLAMP;
                        s_d.base       = base_pos;
                        s_d.tgt_shared = sel_shared;
                        s_d.state      = ST_WAIT_EARLY;
                    end
                end
            end
            ST_WAIT_EARLY: begin
                if (expire) begin
                    clr_en    = 1'b1;
                    clr_pos   = s_q.base + STEP_EARLY;
                    s_d.state = ST_WAIT_VCORE;
                end
            end
            ST_WAIT_VCORE: begin
                if (expire) begin
                    clr_en    = 1'b1;
                    clr_pos   = s_q.base + STEP_VCORE;
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                    if (s_q.tgt_shared) begin
                        s_d.shared_on = 1'b1;
                    end
                end
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, base: '0, tgt_shared: 1'b0,
                     shared_on: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.state != ST_IDLE);
    assign done      = s_q.done;
    assign err       = s_q.err;
    assign shared_on = s_q.shared_on;

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r7_sticky_shared: assert property (@(posedge clk) disable iff (!rst_n)
        shared_on |=> shared_on);
    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    a_r4_no_step_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WAIT_EARLY) |=> (s_q.state != ST_IDLE));
    a_r8_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(s_q.base));

endmodule

// File: rtl/gate_clamp_release_seq.sv
module gate_clamp_release_seq
    import gate_seq_pkg::*;
#(
    parameter int NUM_PORTS  = 7,
    parameter int IDX_W      = 4,
    parameter int WAIT_TICKS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              sel_shared,
    input  logic [IDX_W-1:0]  port_idx,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              shared_on,
    output logic [CTRL_W-1:0] pad_ctrl
);
    logic             in_range;
    logic [POS_W-1:0] base_pos;
    logic             expire;
    logic             clr_en;
    logic [POS_W-1:0] clr_pos;

    gate_target_decode #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) i_decode (
        .sel_shared (sel_shared),
        .port_idx   (port_idx),
        .in_range   (in_range),
        .base_pos   (base_pos)
    );

    gate_tick_timer #(.WAIT_TICKS(WAIT_TICKS)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .tick   (tick),
        .expire (expire)
    );

    gate_clamp_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .sel_shared (sel_shared),
        .in_range   (in_range),
        .base_pos   (base_pos),
        .expire     (expire),
        .clr_en     (clr_en),
        .clr_pos    (clr_pos),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .shared_on  (shared_on)
    );

    gate_ctrl_word i_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .clr_pos (clr_pos),
        .word    (pad_ctrl)
    );

    a_r9_idle_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !$past(start)) |-> $stable(pad_ctrl));

endmodule

// File: tb/test_gate_clamp_release_seq.sv
module test_gate_clamp_release_seq;
    localparam int NP   = 7;
    localparam int WAIT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic        sel_shared = 1'b0;
    logic [3:0]  port_idx = '0;
    logic        busy, done, err, shared_on;
    logic [31:0] pad_ctrl;

    int checks = 0;
    int failures = 0;
    bit tick_en = 1'b1;
    bit finished = 1'b0;
    int cyc = 0;

    gate_clamp_release_seq #(.NUM_PORTS(NP), .IDX_W(4), .WAIT_TICKS(WAIT)) i_gate_clamp_release_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .sel_shared(sel_shared), .port_idx(port_idx), .busy(busy),
        .done(done), .err(err), .shared_on(shared_on), .pad_ctrl(pad_ctrl)
    );

    always #10 clk = ~clk;

    // behavioural reference
    int          m_phase, m_cnt, m_base;
    bit          m_done, m_err, m_shared, m_tgt_sh;
    logic [31:0] m_word;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= 0; m_cnt <= 0; m_base <= 0; m_done <= 0; m_err <= 0;
            m_shared <= 0; m_tgt_sh <= 0; m_word <= '1;
        end else begin
            m_done <= 0; m_err <= 0;
            if (m_phase == 0) begin
                if (start) begin
                    if (sel_shared && m_shared) m_done <= 1;
                    else if (sel_shared) begin
                        m_base <= 29; m_tgt_sh <= 1; m_word[29] <= 1'b0;
                        m_phase <= 1; m_cnt <= 0;
                    end else if (int'(port_idx) < NP) begin
                        m_base <= 3 * int'(port_idx); m_tgt_sh <= 0;
                        m_word[3 * int'(port_idx)] <= 1'b0;
                        m_phase <= 1; m_cnt <= 0;
                    end else begin
                        m_done <= 1; m_err <= 1;
                    end
                end
            end else if (tick) begin
                if (m_cnt + 1 == WAIT) begin
                    m_word[m_base + m_phase] <= 1'b0;
                    m_cnt <= 0;
                    if (m_phase == 2) begin
                        m_phase <= 0; m_done <= 1;
                        if (m_tgt_sh) m_shared <= 1;
                    end else m_phase <= 2;
                end else m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        cyc++;
        tick <= tick_en && (cyc % 4 == 0);
        if (rst_n && !finished) begin
            check(pad_ctrl === m_word, "R2 R3 R4 R5 word", pad_ctrl, m_word);
            check(busy === (m_phase != 0), "R8 busy", {31'b0, busy}, {31'b0, m_phase != 0});
            check(done === m_done, "R6 done", {31'b0, done}, {31'b0, m_done});
            check(err === m_err, "R9 err", {31'b0, err}, {31'b0, m_err});
            check(shared_on === m_shared, "R7 shared_on", {31'b0, shared_on}, {31'b0, m_shared});
        end
    end

    task automatic pulse(input bit sh, input logic [3:0] idx);
        @(negedge clk);
        start = 1'b1; sel_shared = sh; port_idx = idx;
        @(negedge clk);
        start = 1'b0; sel_shared = 1'b0; port_idx = 4'd0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            if (done) return;
            @(negedge clk);
        end
        check(1'b0, "R6 done timeout", 32'd0, 32'd1);
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pad_ctrl === 32'hFFFF_FFFF && !busy && !done && !err && !shared_on,
              "R1 reset", pad_ctrl, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: lowest port
        pulse(1'b0, 4'd0);
        check(pad_ctrl === 32'hFFFF_FFFE && busy, "R4 clamp first", pad_ctrl, 32'hFFFF_FFFE);
        wait_done();
        check(pad_ctrl === 32'hFFFF_FFF8, "R2 port0 bits", pad_ctrl, 32'hFFFF_FFF8);
        check(!busy, "R6 busy low with done", {31'b0, busy}, 32'd0);

        // R8: start for port 2 while port 6 runs is ignored
        pulse(1'b0, 4'd6);
        repeat (2) @(negedge clk);
        pulse(1'b0, 4'd2);
        wait_done();
        check(pad_ctrl === 32'hFFE3_FFF8, "R8 ignored start", pad_ctrl, 32'hFFE3_FFF8);
        @(negedge clk);

        // R5: no ticks, no progress
        tick_en = 1'b0;
        pulse(1'b0, 4'd3);
        repeat (60) @(negedge clk);
        check(pad_ctrl === 32'hFFE3_FDF8 && busy, "R5 parked without tick", pad_ctrl, 32'hFFE3_FDF8);
        tick_en = 1'b1;
        wait_done();
        check(pad_ctrl === 32'hFFE3_F1F8, "R2 port3 bits", pad_ctrl, 32'hFFE3_F1F8);
        @(negedge clk);

        // R9: out-of-range indices
        pulse(1'b0, 4'd7);
        check(err && done && !busy, "R9 idx 7 err", {29'b0, err, done, busy}, 32'd6);
        pulse(1'b0, 4'd15);
        check(err && done, "R9 idx 15 err", {30'b0, err, done}, 32'd3);
        @(negedge clk);
        check(pad_ctrl === 32'hFFE3_F1F8, "R9 word unchanged", pad_ctrl, 32'hFFE3_F1F8);

        // R3: shared group, port index ignored
        pulse(1'b1, 4'd1);
        wait_done();
        check(pad_ctrl === 32'h1FE3_F1F8, "R3 shared bits", pad_ctrl, 32'h1FE3_F1F8);
        @(negedge clk);
        check(shared_on, "R7 sticky set", {31'b0, shared_on}, 32'd1);

        // R7: second shared request completes at once
        pulse(1'b1, 4'd0);
        check(done && !busy, "R7 immediate done", {30'b0, done, busy}, 32'd2);
        @(negedge clk);
        check(pad_ctrl === 32'h1FE3_F1F8 && !busy, "R7 no writes", pad_ctrl, 32'h1FE3_F1F8);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule